// File: doc/BRIEF.md
# Power Fail Detect and Debounce

This block watches an active-low supply-failure input and decides when the system supply is really failing. The input is asynchronous, so it first passes through a two-flop synchronizer. A counter then counts ticks of a free-running 1 MHz debounce timebase for as long as the synchronized level stays low. A high level at any point restarts the count, so short glitches and noise are rejected. When the count reaches a parameterized terminal value between 30 and 63 ticks, the block declares a power failure.

A declared failure sets a status flag that the host can read but cannot clear. The flag clears on its own as soon as the synchronized input returns high. The interrupt output is the status flag gated by an enable bit. There is no acknowledge: the host can only mask the interrupt.

The failure also drives a bus lockout. The lockout engages only while chip select is inactive, so a bus access that is already under way when the failure is declared runs to completion. Once the lockout is engaged, new chip selects are blocked until power returns.

Top module: `pwrfail_guard`

## Requirements
- R1: After reset, pf_status, pf_irq and lockout are 0, and bus_sel follows cs.
- R2: pfail_n passes through two synchronizing flops before it reaches the debounce logic. While the synchronized level is high, the tick count is held at zero. A low run with fewer than DEB_COUNT ticks therefore never sets pf_status.
- R3: pf_status rises on the clock edge at which the DEB_COUNT-th tick_1us is seen with the synchronized input continuously low. Each rise follows a cycle in which tick_1us was 1. With a tick on every cycle and pfail_n driven low before edge 1, pf_status is 0 after edge DEB_COUNT+1 and 1 after edge DEB_COUNT+2.
- R4: Once set, pf_status stays 1 while the synchronized input stays low, whatever ticks arrive. It clears on the edge after the synchronized input is seen high, which is the third edge after pfail_n goes high. No other input clears it.
- R5: pf_irq is 1 exactly when pf_status is 1 and pf_ie is 1. No input acknowledges the interrupt, and clearing pf_ie only masks it.
- R6: lockout goes high only on an edge where pf_status was 1 and cs was 0. It stays high until pf_status clears, and it clears on the edge after pf_status clears.
- R7: bus_sel equals cs while lockout is 0 and equals 0 while lockout is 1. An access in progress when the failure is declared therefore keeps bus_sel high until cs drops.
- R8: The internal tick count never exceeds DEB_COUNT-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfail_n | input | 1 | Raw asynchronous supply-failure input, low means failing |
| tick_1us | input | 1 | One-cycle strobe from the free-running 1 MHz debounce timebase |
| cs | input | 1 | Chip select from the host bus, active high |
| pf_ie | input | 1 | Power fail interrupt enable |
| pf_status | output | 1 | Power fail status flag |
| pf_irq | output | 1 | Maskable power fail interrupt |
| lockout | output | 1 | Bus lockout, active high |
| bus_sel | output | 1 | Chip select after gating by the lockout |

## Verification
A wrong tick count shows at pf_status. It either rises one or more ticks early or late against the DEB_COUNT boundary, or it rises after a low run that a high level should have restarted. Either error is visible within one terminal count of ticks. A lockout register that misses the cs gating is seen on bus_sel on the edge after pf_status rises with an access open. A flag that fails to clear shows three edges after pfail_n returns high. The random runs mix low runs of many lengths with random ticks and chip selects, and they compare every output on every cycle.

// File: rtl/pwrfail_guard.sv
module pwrfail_guard #(
  parameter int DEB_COUNT = 40,
  localparam int CW = $clog2(DEB_COUNT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pfail_n,
  input  logic tick_1us,
  input  logic cs,
  input  logic pf_ie,
  output logic pf_status,
  output logic pf_irq,
  output logic lockout,
  output logic bus_sel
);

  logic          sync_a, sync_b;
  logic [CW-1:0] cnt;
  logic          fail_q, lock_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
    end else begin
      sync_a <= pfail_n;
      sync_b <= sync_a;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      fail_q <= 1'b0;
    end else if (sync_b) begin
      cnt    <= '0;
      fail_q <= 1'b0;
    end else if (!fail_q && tick_1us) begin
      if (cnt == CW'(DEB_COUNT - 1)) fail_q <= 1'b1;
      else                           cnt    <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       lock_q <= 1'b0;
    else if (!fail_q) lock_q <= 1'b0;
    else if (!cs)     lock_q <= 1'b1;

  assign pf_status = fail_q;
  assign pf_irq    = fail_q & pf_ie;
  assign lockout   = lock_q;
  assign bus_sel   = cs & ~lock_q;

  a_r2_high_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sync_b |=> (cnt == '0));
  a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_status) |-> $past(tick_1us));
  a_r4_restore_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sync_b |=> !pf_status);
  a_r6_lock_waits_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockout) |-> $past(!cs && pf_status));
  a_r6_lock_needs_fail: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> $past(pf_status));
  a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEB_COUNT - 1));

endmodule

// File: tb/sim_pwrfail_guard.sv
module sim_pwrfail_guard;
  localparam int DEB = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pfail_n = 1'b1, tick_1us = 1'b0, cs = 1'b0, pf_ie = 1'b0;
  logic pf_status, pf_irq, lockout, bus_sel;

  int n_chk = 0, n_bad = 0;
  logic m_a = 1'b1, m_b = 1'b1, m_fail = 1'b0, m_lock = 1'b0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  pwrfail_guard #(.DEB_COUNT(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .pfail_n(pfail_n), .tick_1us(tick_1us),
    .cs(cs), .pf_ie(pf_ie), .pf_status(pf_status), .pf_irq(pf_irq),
    .lockout(lockout), .bus_sel(bus_sel));

  function automatic logic exp_irq(logic st, logic ie);
    return st & ie;
  endfunction

  function automatic logic exp_sel(logic c, logic lk);
    return c & ~lk;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic old_b, old_fail;
    @(posedge clk);
    old_b = m_b; old_fail = m_fail;
    m_b = m_a; m_a = pfail_n;
    if (old_b) begin m_cnt = 0; m_fail = 1'b0; end
    else if (!m_fail && tick_1us) begin
      if (m_cnt == DEB - 1) m_fail = 1'b1; else m_cnt++;
    end
    if (!old_fail) m_lock = 1'b0; else if (!cs) m_lock = 1'b1;
    #1;
    chk("R3/R4 status", pf_status, m_fail);
    chk("R5 irq", pf_irq, exp_irq(m_fail, pf_ie));
    chk("R6 lockout", lockout, m_lock);
    chk("R7 bus_sel", bus_sel, exp_sel(cs, m_lock));
    @(negedge clk);
  endtask

  initial begin
    #5000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    cs = 1'b1;
    #1;
    chk("R1 status", pf_status, 1'b0);
    chk("R1 irq", pf_irq, 1'b0);
    chk("R1 lockout", lockout, 1'b0);
    chk("R1 bus_sel", bus_sel, 1'b1);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; cs = 1'b0; pf_ie = 1'b1;

    // R3 directed: tick every cycle, exact boundary
    tick_1us = 1'b1; pfail_n = 1'b0;
    for (int i = 1; i <= DEB + 1; i++) step();
    chk("R3 not yet at edge DEB+1", pf_status, 1'b0);
    step();
    chk("R3 set at edge DEB+2", pf_status, 1'b1);
    // R4: ticks ignored while failed; R5 mask only
    pf_ie = 1'b0;
    repeat (10) step();
    chk("R4 held", pf_status, 1'b1);
    chk("R5 masked", pf_irq, 1'b0);
    pf_ie = 1'b1;
    step();
    chk("R5 unmasked again", pf_irq, 1'b1);
    // R4: clears on third edge after high
    pfail_n = 1'b1;
    step(); step();
    chk("R4 still set after two edges", pf_status, 1'b1);
    step();
    chk("R4 cleared third edge", pf_status, 1'b0);

    // R2: one tick short, then glitch restarts count
    pfail_n = 1'b0; tick_1us = 1'b0;
    step(); step();
    for (int i = 0; i < DEB - 1; i++) begin tick_1us = 1'b1; step(); end
    tick_1us = 1'b0; pfail_n = 1'b1; step();
    pfail_n = 1'b0; step(); step(); step();
    chk("R2 short run no fail", pf_status, 1'b0);
    tick_1us = 1'b1;
    for (int i = 0; i < DEB - 1; i++) step();
    chk("R2 restart counts from zero", pf_status, 1'b0);
    step();
    chk("R2 full count after restart", pf_status, 1'b1);
    pfail_n = 1'b1; repeat (4) step();

    // R6/R7: access open during failure completes
    cs = 1'b1; pfail_n = 1'b0;
    repeat (DEB + 5) step();
    chk("R7 open access kept", bus_sel, 1'b1);
    chk("R6 no lock mid access", lockout, 1'b0);
    cs = 1'b0; step(); step();
    chk("R6 locked after cs drop", lockout, 1'b1);
    cs = 1'b1; step();
    chk("R7 new access blocked", bus_sel, 1'b0);
    pfail_n = 1'b1; cs = 1'b0; repeat (5) step();
    chk("R6 lock released", lockout, 1'b0);

    // random mix
    for (int k = 0; k < 200; k++) begin
      int len = $urandom_range(4 * DEB, 1);
      pfail_n = $urandom_range(3, 0) != 0 ? 1'b0 : 1'b1;
      for (int j = 0; j < len; j++) begin
        tick_1us = $urandom_range(1, 0);
        if ($urandom_range(15, 0) == 0) cs = ~cs;
        if ($urandom_range(31, 0) == 0) pf_ie = ~pf_ie;
        if ($urandom_range(199, 0) == 0) pfail_n = ~pfail_n;
        step();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule